// File: doc/BRIEF.md
# Control-Pulse Long/Short Classifier

This block sorts each playback control-track pulse into "long" (1) or "short" (0) and gathers the results as an 8-bit serial pattern. An up/down counter runs on a prescaled count enable. It counts up while the synchronized control pulse is high and down while it is low. At the next rising edge of the pulse, the counter's upper 12 bits are compared against a pair of programmable thresholds. The tape-direction input picks the pair. The counter is then cleared.

The decision has hysteresis. A count at or above the "long" threshold records a 1. A count at or below the "short" threshold records a 0. A count between the two repeats the previous decision, which is also visible as the current duty flag. Each decision enters the pattern register from the right. A full flag rises once eight new decisions have been gathered, so software can read the pattern as one byte. Reading the pattern clears the flag.

Top module: `cpls_classifier`

## Requirements
- R1: After reset, both long thresholds read 0xFFF, both short thresholds read 0x000, and the pattern, status and `pat_full` all read 0.
- R2: Writes with `wr_en` store `wdata[11:0]` at address 0 (forward long), 1 (forward short), 2 (reverse short) or 3 (reverse long). Reads return the stored value zero-extended on `rdata`, combinationally from `addr`.
- R3: The 16-bit duty counter steps once per `cnt_en` cycle. It counts up while the synchronized pulse is high and down while it is low. It saturates at 0 and at 0xFFFF.
- R4: With `pb_mode` high, each rising edge of `ctl_in` produces exactly one evaluation. That evaluation is visible on the third rising clock edge after `ctl_in` is seen high. The counter clears after the evaluation. Holding the pulse high produces no further evaluation.
- R5: Let H be counter bits [15:4]. If H is at or above the selected long threshold, the decision is 1. Otherwise, if H is at or below the selected short threshold, the decision is 0. Otherwise the previous decision repeats. The long test takes priority.
- R6: `dir_rev` = 0 selects addresses 0 and 1 as the long and short thresholds. `dir_rev` = 1 selects addresses 3 and 2.
- R7: Each evaluation shifts the pattern left by one bit and puts the decision in bit 0. The pattern reads at address 4 on `rdata[7:0]`.
- R8: `pat_full` (also status bit 1) rises on the eighth evaluation after the last pattern read. Reading address 4 clears the flag and the decision count.
- R9: Address 5 returns status. Bit 0 is the current duty flag (the latest decision) and bit 1 is the full flag. Reading it clears nothing.
- R10: With `pb_mode` low, rising edges are ignored. The pattern, the flag and the duty flag do not change, and the counter stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_mode | input | 1 | Playback mode; classification is enabled only when high |
| ctl_in | input | 1 | Control-track pulse, asynchronous |
| dir_rev | input | 1 | Tape direction: 0 forward, 1 reverse |
| cnt_en | input | 1 | Prescaled count enable (one in four clocks in normal use) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| pat_full | output | 1 | Eight decisions gathered since the last pattern read |

## Verification
A wrong counter direction, a missing saturation, or a swapped threshold pair corrupts exactly one decision. That bit shows in the duty flag three clocks after the pulse edge. It then stays in the pattern byte for the next seven evaluations. An off-by-one in the decision count shows on `pat_full` one evaluation early or late. A repeated or missed strobe shifts the whole byte by a position. Because of this, the bench reads the status after every pulse and compares the full pattern at two points that straddle a flag cycle.

// File: rtl/cpls_pkg.sv
package cpls_pkg;
  localparam int TH_W   = 12;
  localparam int CNT_W  = 16;
  localparam int PAT_W  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FWD_LONG  = 3'd0,
    A_FWD_SHORT = 3'd1,
    A_REV_SHORT = 3'd2,
    A_REV_LONG  = 3'd3,
    A_PATTERN   = 3'd4,
    A_STATUS    = 3'd5
  } reg_addr_e;

  // Hysteresis decision: long test wins, then short test, else keep.
  function automatic logic ls_decide(input logic hit_long, input logic hit_short,
                                     input logic prev);
    if (hit_long)       return 1'b1;
    else if (hit_short) return 1'b0;
    else                return prev;
  endfunction
endpackage

// File: rtl/cpls_edge_sync.sv
module cpls_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cpls_duty_counter.sv
module cpls_duty_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         up,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clear)          count <= '0;
    else if (step) begin
      if (up && count != TOP)        count <= count + 1'b1;
      else if (!up && count != '0)   count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/cpls_pattern_reg.sv
module cpls_pattern_reg #(
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             bit_in,
  input  logic             rd_clr,
  output logic [PAT_W-1:0] pattern,
  output logic             full
);
  localparam int NW = $clog2(PAT_W) + 1;
  localparam logic [NW-1:0] LAST = NW'(PAT_W - 1);

  logic [NW-1:0] n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pattern <= '0;
    else if (shift) pattern <= {pattern[PAT_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q  <= '0;
      full <= 1'b0;
    end else if (rd_clr) begin
      n_q  <= shift ? NW'(1) : '0;
      full <= 1'b0;
    end else if (shift) begin
      if (n_q == LAST) begin
        n_q  <= '0;
        full <= 1'b1;
      end else begin
        n_q <= n_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpls_classifier.sv
module cpls_classifier
  import cpls_pkg::*;
#(
  parameter int TW  = TH_W,
  parameter int CW  = CNT_W,
  parameter int PW  = PAT_W,
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pb_mode,
  input  logic          ctl_in,
  input  logic          dir_rev,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pat_full
);
  localparam logic [TW-1:0] TH_MAX = {TW{1'b1}};

  logic [TW-1:0] th_fl, th_fs, th_rs, th_rl;
  logic          lvl, rise, eval_stb, rd_pat, decision;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] hi, sel_long, sel_short;
  logic [PW-1:0] pat_q;

  // threshold registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_fl <= TH_MAX;
      th_fs <= '0;
      th_rs <= '0;
      th_rl <= TH_MAX;
    end else if (wr_en) begin
      case (addr)
        A_FWD_LONG:  th_fl <= wdata[TW-1:0];
        A_FWD_SHORT: th_fs <= wdata[TW-1:0];
        A_REV_SHORT: th_rs <= wdata[TW-1:0];
        A_REV_LONG:  th_rl <= wdata[TW-1:0];
        default: ;
      endcase
    end
  end

  cpls_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ctl_in), .level(lvl), .rise(rise)
  );

  assign eval_stb = rise & pb_mode;

  cpls_duty_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(eval_stb | ~pb_mode),
    .step(cnt_en), .up(lvl), .count(cnt_q)
  );

  assign hi        = cnt_q[CW-1 -: TW];
  assign sel_long  = dir_rev ? th_rl : th_fl;
  assign sel_short = dir_rev ? th_rs : th_fs;
  assign decision  = ls_decide(hi >= sel_long, hi <= sel_short, pat_q[0]);
  assign rd_pat    = rd_en && (addr == A_PATTERN);

  cpls_pattern_reg #(.PAT_W(PW)) u_pat (
    .clk(clk), .rst_n(rst_n), .shift(eval_stb), .bit_in(decision),
    .rd_clr(rd_pat), .pattern(pat_q), .full(pat_full)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_FWD_LONG:  rdata[TW-1:0] = th_fl;
      A_FWD_SHORT: rdata[TW-1:0] = th_fs;
      A_REV_SHORT: rdata[TW-1:0] = th_rs;
      A_REV_LONG:  rdata[TW-1:0] = th_rl;
      A_PATTERN:   rdata[PW-1:0] = pat_q;
      A_STATUS:    rdata[1:0]    = {pat_full, pat_q[0]};
      default:     rdata         = '0;
    endcase
  end
endmodule

// File: rtl/cpls_classifier_chk.sv
module cpls_classifier_chk #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pb_mode,
  input logic          cnt_en,
  input logic          lvl,
  input logic          eval_stb,
  input logic          rd_pat,
  input logic [CW-1:0] cnt_q,
  input logic [PW-1:0] pat_q,
  input logic          pat_full
);
  // R4
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb |=> !eval_stb);
  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb |=> cnt_q == '0);
  // R7
  pat_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb |=> pat_q[PW-1:1] == $past(pat_q[PW-2:0]));
  // R7
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_stb |=> $stable(pat_q));
  // R8
  full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pat |=> !pat_full);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_mode |-> !eval_stb);
  // R3
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !lvl && pb_mode && !eval_stb) |=> cnt_q == '0);
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !eval_stb && pb_mode) |=> $stable(cnt_q));
endmodule

bind cpls_classifier cpls_classifier_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pb_mode(pb_mode), .cnt_en(cnt_en), .lvl(lvl),
  .eval_stb(eval_stb), .rd_pat(rd_pat), .cnt_q(cnt_q), .pat_q(pat_q),
  .pat_full(pat_full)
);

// File: tb/sim_cpls_classifier.sv
module sim_cpls_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pb_mode = 1'b1, ctl_in = 1'b0, dir_rev = 1'b0, cnt_en = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pat_full;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cpls_classifier u0 (
    .clk(clk), .rst_n(rst_n), .pb_mode(pb_mode), .ctl_in(ctl_in),
    .dir_rev(dir_rev), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pat_full(pat_full)
  );

  // {dir, up, down, expected}; H = (up-down saturated at 0) >> 4
  // thresholds: fwd long 20, fwd short 10, rev long 40, rev short 30
  localparam logic [25:0] VEC [10] = '{
    {1'b0, 12'd400, 12'd0,  1'b1},  // R5 H=25 long
    {1'b0, 12'd100, 12'd0,  1'b0},  // R5 H=6 short
    {1'b0, 12'd240, 12'd0,  1'b0},  // R5 H=15 hold 0
    {1'b0, 12'd320, 12'd0,  1'b1},  // R5 H=20 equal long
    {1'b0, 12'd250, 12'd50, 1'b1},  // R3 up/down H=12 hold 1
    {1'b0, 12'd175, 12'd0,  1'b0},  // R5 H=10 equal short
    {1'b1, 12'd400, 12'd0,  1'b0},  // R6 rev H=25 short
    {1'b1, 12'd660, 12'd0,  1'b1},  // R6 rev H=41 long
    {1'b1, 12'd560, 12'd0,  1'b1},  // R6 rev H=35 hold 1
    {1'b0, 12'd5,   12'd50, 1'b0}   // R3 floor at 0, H=0
  };

  logic [7:0] exp_pat = '0;
  int         exp_n = 0;
  logic       exp_full = 1'b0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic enables(input int n);
    if (n > 0) begin
      @(negedge clk); cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  // starts with ctl high and counter freshly cleared; ends after the next evaluation
  task automatic pulse(input int up, input int dn);
    enables(up);
    @(negedge clk); ctl_in = 1'b0;
    repeat (3) @(negedge clk);
    enables(dn);
    @(negedge clk); ctl_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic void model_push(input logic b);
    exp_pat = {exp_pat[6:0], b};
    exp_n++;
    if (exp_n == 8) begin exp_n = 0; exp_full = 1'b1; end
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd0, d); check("R1 fwd long", d, 16'h0FFF);
    rd(3'd1, d); check("R1 fwd short", d, 16'h0000);
    rd(3'd2, d); check("R1 rev short", d, 16'h0000);
    rd(3'd3, d); check("R1 rev long", d, 16'h0FFF);
    rd(3'd5, d); check("R1 status", d, 16'h0000);
    rd(3'd4, d); check("R1 pattern", d, 16'h0000);
    check("R1 pat_full", {15'd0, pat_full}, 16'd0);

    // R2 threshold programming, upper bits dropped
    wr(3'd0, 16'hF014); wr(3'd1, 16'd10); wr(3'd2, 16'd30); wr(3'd3, 16'd40);
    rd(3'd0, d); check("R2 fwd long", d, 16'd20);
    rd(3'd2, d); check("R2 rev short", d, 16'd30);
    rd(3'd3, d); check("R2 rev long", d, 16'd40);

    // prime: first rising edge evaluates H=0 -> 0 (R5), then clear via pattern read
    @(negedge clk); ctl_in = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd5, d); check("R4 no result before third edge", d, 16'h0000);
    model_push(1'b0);
    rd(3'd4, d); check("R7 prime pattern", d, {8'd0, exp_pat});
    exp_n = 0; exp_full = 1'b0;

    // vector table
    for (int i = 0; i < 10; i++) begin
      dir_rev = VEC[i][25];
      pulse(int'(VEC[i][24:13]), int'(VEC[i][12:1]));
      model_push(VEC[i][0]);
      rd(3'd5, d);
      check($sformatf("R5 vec%0d duty flag", i), {15'd0, d[0]}, {15'd0, VEC[i][0]});
      check($sformatf("R8 vec%0d full flag", i), {15'd0, d[1]}, {15'd0, exp_full});
      if (i == 7) begin
        check("R8 pat_full port", {15'd0, pat_full}, 16'd1);
        rd(3'd4, d); check("R7 pattern after eight", d, {8'd0, exp_pat});
        exp_n = 0; exp_full = 1'b0;
        check("R8 flag cleared by read", {15'd0, pat_full}, 16'd0);
      end
    end
    rd(3'd5, d); check("R9 status read has no side effect", d, {14'd0, exp_full, exp_pat[0]});
    rd(3'd4, d); check("R7 pattern after ten", d, {8'd0, exp_pat});
    exp_n = 0; exp_full = 1'b0;

    // R4 held-high pulse gives no further evaluation
    dir_rev = 1'b0;
    repeat (30) @(negedge clk);
    rd(3'd4, d); check("R4 no repeat while high", d, {8'd0, exp_pat});

    // R10 playback off: edges ignored, counter held at zero
    @(negedge clk); pb_mode = 1'b0;
    pulse(400, 0);
    rd(3'd4, d); check("R10 pattern unchanged", d, {8'd0, exp_pat});
    rd(3'd5, d); check("R10 status unchanged", d, {14'd0, exp_full, exp_pat[0]});
    @(negedge clk); pb_mode = 1'b1;
    // counter starts from zero: 175 up -> H=10 -> short 0 even though 400 counted above
    pulse(175, 0);
    model_push(1'b0);
    rd(3'd4, d); check("R10 R3 counter held clear", d, {8'd0, exp_pat});

    // R5 priority: long threshold below short threshold, long wins
    wr(3'd0, 16'd5); wr(3'd1, 16'd50);
    pulse(160, 0);   // H=10: >=5 and <=50
    model_push(1'b1);
    rd(3'd5, d); check("R5 long wins overlap", {15'd0, d[0]}, 16'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule